// File: doc/BRIEF.md
# Checkpoint Error Recovery Controller

This block guards the commit of architected processor state. The pipeline offers one proposed state change per cycle, such as a register write or a cache write. Each offer comes with a 3-bit error code from the check logic upstream. Changes that arrive clean, or that were repaired by the error-correction logic, are written into a checkpoint store. The store keeps one parity bit per word and remembers the program counter of the most recent good update.

A change that carries an uncorrectable fault is not committed. The controller records the fault in an eight-entry circular log. It then issues a one-cycle restart that carries the saved program counter, so that a transient fault can clear when the work is replayed. After a restart, the controller watches a window of committed updates. If the same uncorrectable fault type comes back inside that window, the controller stops retrying. It raises a handoff request so that the checkpoint can move to a spare processor. Once that request is acknowledged, it parks in a halted state until reset.

The checkpoint store has a read port, which the handoff transfer uses to drain the saved state.

Top module: `ckpt_guard`

## Requirements
- R1: An update accepted (upd_valid and upd_ready high at a rising edge) with error code 0 (none) is presented on commit_valid, commit_addr and commit_data in the next cycle, with its raw data.
- R2: An accepted update with error code 1 (corrected) commits the value on upd_fix instead of upd_data.
- R3: An accepted update with error code 2 (array parity), 3 (control fault), 4 (uncorrectable ECC) or any higher code is not committed. In the next cycle, log_we is high for one cycle, with log_type and log_addr equal to the faulty update's code and address.
- R4: Log placement and counting:
  - A log write whose type and address match a valid entry rewrites that entry (lowest index first) with its count incremented, saturating at 2^LOG_CNTW-1.
  - Any other log write takes the next free-running slot with count 1, and the slot index wraps from LOG_DEPTH-1 to 0.
- R5: The cycle after a log write that is not an escalation, restart_pulse is high for exactly one cycle. restart_pc then equals the program counter of the last committed update, or RESET_PC if nothing has been committed since reset.
- R6: upd_ready is low during the log cycle, during the restart cycle and for RESTART_WAIT cycles after it, and high again in the cycle that follows.
- R7: An uncorrectable fault whose code equals the code that caused the latest restart, arriving before WINDOW updates have committed since that restart, is logged and then escalated without a restart. handoff_req then stays high until handoff_ack is seen.
- R8: Once WINDOW updates have committed after a restart, a later fault of the same code is treated as new and restarts again. A fault with a different code never escalates.
- R9: The cycle after handoff_ack is sampled during escalation, halted is high, and it stays high with upd_ready low and no commits until reset.
- R10: The checkpoint store read port returns the latest committed value for each address, and 0 after reset, with ck_rd_perr low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Proposed state update present |
| upd_ready | output | 1 | Controller accepts updates |
| upd_err | input | 3 | Error code of the update |
| upd_addr | input | AW | State address written by the update |
| upd_data | input | DW | Raw update value |
| upd_fix | input | DW | Corrected value, used when the code is 1 |
| upd_pc | input | PCW | Program counter tied to the update |
| commit_valid | output | 1 | Committed update present |
| commit_addr | output | AW | Address of the committed update |
| commit_data | output | DW | Value committed |
| log_we | output | 1 | Log entry write strobe |
| log_idx | output | clog2(LOG_DEPTH) | Log slot being written |
| log_type | output | 3 | Fault code being logged |
| log_addr | output | AW | Fault address being logged |
| log_count | output | LOG_CNTW | Occurrence count written to the slot |
| restart_pulse | output | 1 | One-cycle restart request |
| restart_pc | output | PCW | Program counter to resume from |
| handoff_req | output | 1 | Request to migrate the checkpoint |
| handoff_ack | input | 1 | Migration request accepted |
| halted | output | 1 | Controller parked after handoff |
| ck_rd_addr | input | AW | Checkpoint store read address |
| ck_rd_data | output | DW | Checkpoint store read data |
| ck_rd_perr | output | 1 | Parity mismatch on the read word |

## Verification
The properties assume that handoff_ack is only raised while handoff_req is high. They also assume that upd_err, upd_addr and the data inputs are stable whenever upd_valid is high. The bench drives every input on the falling edge and pulses the acknowledge only after it has observed the request for several cycles. Offers are only made once upd_ready has been seen high again after a restart window. The exception is the test of offers that arrive while the controller is halted, and those offers must be refused.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_LOG,
    ST_RESTART,
    ST_WAIT,
    ST_ESC,
    ST_HALT
  } ckpt_state_e;

  localparam logic [2:0] ERR_NONE = 3'd0;
  localparam logic [2:0] ERR_CORR = 3'd1;
  localparam logic [2:0] ERR_APAR = 3'd2;
  localparam logic [2:0] ERR_CTRL = 3'd3;
  localparam logic [2:0] ERR_UECC = 3'd4;

  // Codes from 2 upward block the commit; unassigned codes fail safe.
  function automatic logic is_fatal(input logic [2:0] code);
    return code >= ERR_APAR;
  endfunction

  function automatic logic is_repaired(input logic [2:0] code);
    return code == ERR_CORR;
  endfunction

endpackage

// File: rtl/ckpt_store.sv
module ckpt_store #(
  parameter int AW       = 4,
  parameter int DW       = 32,
  parameter int PCW      = 32,
  parameter logic [PCW-1:0] RESET_PC = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [PCW-1:0] wr_pc,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           rd_perr,
  output logic [PCW-1:0] saved_pc
);

  localparam int DEPTH = 1 << AW;

  function automatic logic word_par(input logic [DW-1:0] w);
    return ^w;
  endfunction

  logic [DW-1:0]  word_q [DEPTH];
  logic [DEPTH-1:0] par_q;
  logic [PCW-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) word_q[i] <= '0;
      par_q <= '0;
      pc_q  <= RESET_PC;
    end else if (wr_en) begin
      word_q[wr_addr] <= wr_data;
      par_q[wr_addr]  <= word_par(wr_data);
      pc_q            <= wr_pc;
    end
  end

  assign rd_data  = word_q[rd_addr];
  assign rd_perr  = word_par(word_q[rd_addr]) != par_q[rd_addr];
  assign saved_pc = pc_q;

endmodule

// File: rtl/ckpt_log.sv
module ckpt_log #(
  parameter int AW        = 4,
  parameter int LOG_DEPTH = 8,
  parameter int CW        = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req,
  input  logic [2:0]                   req_type,
  input  logic [AW-1:0]                req_addr,
  output logic                         we,
  output logic [$clog2(LOG_DEPTH)-1:0] idx,
  output logic [2:0]                   typ,
  output logic [AW-1:0]                addr,
  output logic [CW-1:0]                cnt
);

  localparam int IW = $clog2(LOG_DEPTH);
  localparam logic [IW-1:0] LAST_SLOT = IW'(LOG_DEPTH - 1);

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] c);
    return (c == {CW{1'b1}}) ? c : c + 1'b1;
  endfunction

  logic [LOG_DEPTH-1:0] ent_v;
  logic [2:0]           ent_t [LOG_DEPTH];
  logic [AW-1:0]        ent_a [LOG_DEPTH];
  logic [CW-1:0]        ent_c [LOG_DEPTH];
  logic [IW-1:0]        ptr_q;

  logic [LOG_DEPTH-1:0] hit_vec;
  logic [IW-1:0]        hit_idx;
  logic                 any_hit;

  for (genvar g = 0; g < LOG_DEPTH; g++) begin : g_match
    assign hit_vec[g] = ent_v[g] && (ent_t[g] == req_type) && (ent_a[g] == req_addr);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = LOG_DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end

  assign any_hit = |hit_vec;
  assign we      = req;
  assign idx     = any_hit ? hit_idx : ptr_q;
  assign typ     = req_type;
  assign addr    = req_addr;
  assign cnt     = any_hit ? sat_inc(ent_c[hit_idx]) : CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
      ptr_q <= '0;
      for (int i = 0; i < LOG_DEPTH; i++) begin
        ent_t[i] <= '0;
        ent_a[i] <= '0;
        ent_c[i] <= '0;
      end
    end else if (req) begin
      ent_v[idx] <= 1'b1;
      ent_t[idx] <= req_type;
      ent_a[idx] <= req_addr;
      ent_c[idx] <= cnt;
      if (!any_hit) ptr_q <= (ptr_q == LAST_SLOT) ? '0 : ptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/ckpt_fsm.sv
module ckpt_fsm
  import ckpt_pkg::*;
#(
  parameter int AW           = 4,
  parameter int WINDOW       = 16,
  parameter int RESTART_WAIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_valid,
  input  logic [2:0]    upd_err,
  input  logic [AW-1:0] upd_addr,
  input  logic          handoff_ack,
  output logic          upd_ready,
  output logic          commit_go,
  output logic          log_req,
  output logic [2:0]    log_type,
  output logic [AW-1:0] log_addr,
  output logic          restart_go,
  output logic          handoff_req,
  output logic          halted
);

  localparam int WW = $clog2(WINDOW + 1);
  localparam int TW = $clog2(RESTART_WAIT + 1);
  localparam logic [WW-1:0] WIN_LAST  = WW'(WINDOW - 1);
  localparam logic [TW-1:0] WAIT_LAST = TW'(RESTART_WAIT - 1);

  ckpt_state_e   state_q;
  logic [2:0]    cap_type_q;
  logic [AW-1:0] cap_addr_q;
  logic          recur_q;
  logic          armed_q;
  logic [2:0]    armed_type_q;
  logic [WW-1:0] win_q;
  logic [TW-1:0] wait_q;

  logic accept;
  logic err_go;
  logic recur_hit;

  assign accept    = upd_valid && (state_q == ST_RUN);
  assign commit_go = accept && !is_fatal(upd_err);
  assign err_go    = accept && is_fatal(upd_err);
  assign recur_hit = armed_q && (upd_err == armed_type_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_RUN;
      cap_type_q   <= ERR_NONE;
      cap_addr_q   <= '0;
      recur_q      <= 1'b0;
      armed_q      <= 1'b0;
      armed_type_q <= ERR_NONE;
      win_q        <= '0;
      wait_q       <= '0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (err_go) begin
            cap_type_q <= upd_err;
            cap_addr_q <= upd_addr;
            recur_q    <= recur_hit;
            state_q    <= ST_LOG;
          end else if (commit_go && armed_q) begin
            if (win_q == WIN_LAST) begin
              armed_q <= 1'b0;
              win_q   <= '0;
            end else begin
              win_q <= win_q + 1'b1;
            end
          end
        end
        ST_LOG: state_q <= recur_q ? ST_ESC : ST_RESTART;
        ST_RESTART: begin
          armed_q      <= 1'b1;
          armed_type_q <= cap_type_q;
          win_q        <= '0;
          wait_q       <= WAIT_LAST;
          state_q      <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wait_q == '0) state_q <= ST_RUN;
          else              wait_q  <= wait_q - 1'b1;
        end
        ST_ESC:  if (handoff_ack) state_q <= ST_HALT;
        ST_HALT: state_q <= ST_HALT;
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign upd_ready   = (state_q == ST_RUN);
  assign log_req     = (state_q == ST_LOG);
  assign log_type    = cap_type_q;
  assign log_addr    = cap_addr_q;
  assign restart_go  = (state_q == ST_RESTART);
  assign handoff_req = (state_q == ST_ESC);
  assign halted      = (state_q == ST_HALT);

endmodule

// File: rtl/ckpt_guard.sv
module ckpt_guard
  import ckpt_pkg::*;
#(
  parameter int AW           = 4,
  parameter int DW           = 32,
  parameter int PCW          = 32,
  parameter int WINDOW       = 16,
  parameter int RESTART_WAIT = 4,
  parameter int LOG_DEPTH    = 8,
  parameter int LOG_CNTW     = 4,
  parameter logic [PCW-1:0] RESET_PC = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         upd_valid,
  output logic                         upd_ready,
  input  logic [2:0]                   upd_err,
  input  logic [AW-1:0]                upd_addr,
  input  logic [DW-1:0]                upd_data,
  input  logic [DW-1:0]                upd_fix,
  input  logic [PCW-1:0]               upd_pc,
  output logic                         commit_valid,
  output logic [AW-1:0]                commit_addr,
  output logic [DW-1:0]                commit_data,
  output logic                         log_we,
  output logic [$clog2(LOG_DEPTH)-1:0] log_idx,
  output logic [2:0]                   log_type,
  output logic [AW-1:0]                log_addr,
  output logic [LOG_CNTW-1:0]          log_count,
  output logic                         restart_pulse,
  output logic [PCW-1:0]               restart_pc,
  output logic                         handoff_req,
  input  logic                         handoff_ack,
  output logic                         halted,
  input  logic [AW-1:0]                ck_rd_addr,
  output logic [DW-1:0]                ck_rd_data,
  output logic                         ck_rd_perr
);

  function automatic logic [DW-1:0] pick_word(input logic [2:0] code,
                                              input logic [DW-1:0] raw,
                                              input logic [DW-1:0] fixed);
    return is_repaired(code) ? fixed : raw;
  endfunction

  logic          commit_go;
  logic          log_req;
  logic [2:0]    fault_type;
  logic [AW-1:0] fault_addr;
  logic [DW-1:0] commit_word;

  assign commit_word = pick_word(upd_err, upd_data, upd_fix);

  ckpt_fsm #(
    .AW(AW), .WINDOW(WINDOW), .RESTART_WAIT(RESTART_WAIT)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_err(upd_err), .upd_addr(upd_addr),
    .handoff_ack(handoff_ack),
    .upd_ready(upd_ready), .commit_go(commit_go),
    .log_req(log_req), .log_type(fault_type), .log_addr(fault_addr),
    .restart_go(restart_pulse), .handoff_req(handoff_req), .halted(halted)
  );

  ckpt_log #(
    .AW(AW), .LOG_DEPTH(LOG_DEPTH), .CW(LOG_CNTW)
  ) log_i (
    .clk(clk), .rst_n(rst_n),
    .req(log_req), .req_type(fault_type), .req_addr(fault_addr),
    .we(log_we), .idx(log_idx), .typ(log_type), .addr(log_addr), .cnt(log_count)
  );

  ckpt_store #(
    .AW(AW), .DW(DW), .PCW(PCW), .RESET_PC(RESET_PC)
  ) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(commit_go), .wr_addr(upd_addr), .wr_data(commit_word), .wr_pc(upd_pc),
    .rd_addr(ck_rd_addr), .rd_data(ck_rd_data), .rd_perr(ck_rd_perr),
    .saved_pc(restart_pc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_valid <= 1'b0;
      commit_addr  <= '0;
      commit_data  <= '0;
    end else begin
      commit_valid <= commit_go;
      if (commit_go) begin
        commit_addr <= upd_addr;
        commit_data <= commit_word;
      end
    end
  end

endmodule

// File: rtl/ckpt_guard_chk.sv
module ckpt_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_valid,
  input logic       upd_ready,
  input logic [2:0] upd_err,
  input logic       commit_valid,
  input logic       log_we,
  input logic       restart_pulse,
  input logic       handoff_req,
  input logic       handoff_ack,
  input logic       halted
);

  logic fire;
  assign fire = upd_valid && upd_ready;

  // R1
  clean_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && upd_err == 3'd0) |=> commit_valid);

  // R2
  fixed_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && upd_err == 3'd1) |=> commit_valid);

  // R3
  fatal_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && upd_err >= 3'd2) |=> (!commit_valid && log_we));

  // R5
  restart_after_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |-> $past(log_we));

  // R5
  restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |=> !restart_pulse);

  // R6
  restart_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_we || restart_pulse) |-> !upd_ready);

  // R7
  handoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (handoff_req && !handoff_ack) |=> handoff_req);

  // R7
  event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({log_we, restart_pulse, handoff_req, halted}));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !upd_ready && !commit_valid));

endmodule

bind ckpt_guard ckpt_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
  .upd_err(upd_err), .commit_valid(commit_valid), .log_we(log_we),
  .restart_pulse(restart_pulse), .handoff_req(handoff_req),
  .handoff_ack(handoff_ack), .halted(halted)
);

// File: tb/ckpt_guard_tb.sv
module ckpt_guard_tb_top;

  localparam int AW = 4;
  localparam int DW = 32;
  localparam int PCW = 32;
  localparam int WINDOW = 4;
  localparam int RWAIT = 4;
  localparam int LDEP = 8;
  localparam int LCW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_valid = 1'b0;
  logic upd_ready;
  logic [2:0] upd_err = '0;
  logic [AW-1:0] upd_addr = '0;
  logic [DW-1:0] upd_data = '0;
  logic [DW-1:0] upd_fix = '0;
  logic [PCW-1:0] upd_pc = '0;
  logic commit_valid;
  logic [AW-1:0] commit_addr;
  logic [DW-1:0] commit_data;
  logic log_we;
  logic [2:0] log_idx;
  logic [2:0] log_type;
  logic [AW-1:0] log_addr;
  logic [LCW-1:0] log_count;
  logic restart_pulse;
  logic [PCW-1:0] restart_pc;
  logic handoff_req;
  logic handoff_ack = 1'b0;
  logic halted;
  logic [AW-1:0] ck_rd_addr = '0;
  logic [DW-1:0] ck_rd_data;
  logic ck_rd_perr;

  always #2 clk = ~clk;

  ckpt_guard #(
    .AW(AW), .DW(DW), .PCW(PCW), .WINDOW(WINDOW), .RESTART_WAIT(RWAIT),
    .LOG_DEPTH(LDEP), .LOG_CNTW(LCW), .RESET_PC('0)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_err(upd_err), .upd_addr(upd_addr), .upd_data(upd_data), .upd_fix(upd_fix),
    .upd_pc(upd_pc), .commit_valid(commit_valid), .commit_addr(commit_addr),
    .commit_data(commit_data), .log_we(log_we), .log_idx(log_idx),
    .log_type(log_type), .log_addr(log_addr), .log_count(log_count),
    .restart_pulse(restart_pulse), .restart_pc(restart_pc),
    .handoff_req(handoff_req), .handoff_ack(handoff_ack), .halted(halted),
    .ck_rd_addr(ck_rd_addr), .ck_rd_data(ck_rd_data), .ck_rd_perr(ck_rd_perr)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench-side model state
  logic [DW-1:0]  smem [16];
  logic [PCW-1:0] last_pc;
  int             seq;
  bit             lv [LDEP];
  logic [2:0]     lt [LDEP];
  logic [AW-1:0]  la [LDEP];
  logic [LCW-1:0] lc [LDEP];
  int             lptr;

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) smem[i] = '0;
    for (int i = 0; i < LDEP; i++) begin
      lv[i] = 0; lt[i] = '0; la[i] = '0; lc[i] = '0;
    end
    lptr = 0;
    last_pc = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    upd_valid = 1'b0;
    handoff_ack = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic do_commit(input string rq, input logic [2:0] et, input logic [AW-1:0] ad,
                           input logic [DW-1:0] d, input logic [DW-1:0] f);
    logic [DW-1:0] exp;
    seq++;
    exp = (et == 3'd1) ? f : d;
    @(negedge clk);
    upd_valid = 1'b1; upd_err = et; upd_addr = ad; upd_data = d; upd_fix = f;
    upd_pc = 32'h1000 + 32'(seq * 4);
    @(negedge clk);
    upd_valid = 1'b0;
    check({rq, " commit_valid"}, 64'(commit_valid), 64'd1);
    check({rq, " commit_addr"}, 64'(commit_addr), 64'(ad));
    check({rq, " commit_data"}, 64'(commit_data), 64'(exp));
    smem[ad] = exp;
    last_pc = 32'h1000 + 32'(seq * 4);
  endtask

  task automatic clear_window();
    for (int i = 0; i < WINDOW; i++)
      do_commit("R8 window", 3'd0, AW'(i), 32'hC0DE_0000 + 32'(seq), 32'h0);
  endtask

  task automatic read_check(input string rq, input logic [AW-1:0] ad);
    @(negedge clk);
    ck_rd_addr = ad;
    #1;
    check({rq, " store data"}, 64'(ck_rd_data), 64'(smem[ad]));
    check({rq, " store perr"}, 64'(ck_rd_perr), 64'd0);
  endtask

  task automatic do_fatal(input logic [2:0] et, input logic [AW-1:0] ad, input bit esc);
    int hi;
    int wi;
    logic [LCW-1:0] ec;
    hi = -1;
    for (int i = LDEP - 1; i >= 0; i--)
      if (lv[i] && lt[i] == et && la[i] == ad) hi = i;
    if (hi >= 0) begin
      wi = hi;
      ec = (lc[hi] == {LCW{1'b1}}) ? lc[hi] : LCW'(lc[hi] + 1'b1);
    end else begin
      wi = lptr;
      ec = LCW'(1);
    end
    @(negedge clk);
    upd_valid = 1'b1; upd_err = et; upd_addr = ad; upd_data = 32'hBAD0_0000; upd_fix = '0;
    upd_pc = 32'hFFFF_0000;
    @(negedge clk);
    upd_valid = 1'b0;
    check("R3 no commit", 64'(commit_valid), 64'd0);
    check("R3 log_we", 64'(log_we), 64'd1);
    check("R3 log_type", 64'(log_type), 64'(et));
    check("R3 log_addr", 64'(log_addr), 64'(ad));
    check("R4 log_idx", 64'(log_idx), 64'(wi));
    check("R4 log_count", 64'(log_count), 64'(ec));
    check("R6 ready low in log", 64'(upd_ready), 64'd0);
    lv[wi] = 1; lt[wi] = et; la[wi] = ad; lc[wi] = ec;
    if (hi < 0) lptr = (lptr + 1) % LDEP;
    @(negedge clk);
    if (!esc) begin
      check("R5 restart_pulse", 64'(restart_pulse), 64'd1);
      check("R5 restart_pc", 64'(restart_pc), 64'(last_pc));
      check("R5 log_we drop", 64'(log_we), 64'd0);
      check("R8 no handoff", 64'(handoff_req), 64'd0);
      for (int i = 0; i < RWAIT; i++) begin
        @(negedge clk);
        check("R6 ready low in wait", 64'(upd_ready), 64'd0);
        check("R5 single pulse", 64'(restart_pulse), 64'd0);
      end
      @(negedge clk);
      check("R6 ready back", 64'(upd_ready), 64'd1);
    end else begin
      check("R7 handoff_req", 64'(handoff_req), 64'd1);
      check("R7 no restart", 64'(restart_pulse), 64'd0);
    end
  endtask

  task automatic t_reset();
    check("R6 ready after reset", 64'(upd_ready), 64'd1);
    check("R1 idle commit", 64'(commit_valid), 64'd0);
    check("R5 idle restart", 64'(restart_pulse), 64'd0);
    check("R7 idle handoff", 64'(handoff_req), 64'd0);
    check("R9 idle halted", 64'(halted), 64'd0);
    check("R3 idle log", 64'(log_we), 64'd0);
    read_check("R10 reset", 4'd9);
  endtask

  task automatic t_clean();
    do_commit("R1 a", 3'd0, 4'd1, 32'h1111_0001, 32'hDEAD_BEEF);
    do_commit("R1 b", 3'd0, 4'd2, 32'h2222_0002, 32'h0);
    do_commit("R1 c", 3'd0, 4'd15, 32'hFFFF_000F, 32'h0);
    do_commit("R1 d", 3'd0, 4'd1, 32'h1111_0011, 32'h0);
    read_check("R10 a", 4'd1);
    read_check("R10 b", 4'd15);
  endtask

  task automatic t_corr();
    do_commit("R2 fix", 3'd1, 4'd2, 32'h0000_0BAD, 32'h0000_0600D);
    read_check("R2 stored fix", 4'd2);
    check("R2 store value", 64'(smem[2]), 64'h0000_0600D);
  endtask

  task automatic t_fatal();
    do_fatal(3'd2, 4'd3, 0);
    read_check("R3 no store write", 4'd3);
    clear_window();
  endtask

  task automatic t_window();
    do_fatal(3'd3, 4'd5, 0);
    for (int i = 0; i < WINDOW - 1; i++)
      do_commit("R8 partial", 3'd0, 4'd7, 32'h7700 + 32'(i), 32'h0);
    do_fatal(3'd2, 4'd6, 0);
    clear_window();
    do_fatal(3'd2, 4'd6, 0);
    clear_window();
  endtask

  task automatic t_log();
    for (int i = 0; i < 6; i++) begin
      do_fatal(3'd4, AW'(8 + i), 0);
      clear_window();
    end
    check("R4 pointer wrapped", 64'(la[0]), 64'd13);
    for (int i = 0; i < 3; i++) begin
      do_fatal(3'd4, 4'd8, 0);
      clear_window();
    end
    check("R4 saturated", 64'(lc[3]), 64'd3);
  endtask

  task automatic t_escalate();
    do_fatal(3'd4, 4'd12, 0);
    for (int i = 0; i < WINDOW - 1; i++)
      do_commit("R7 inside window", 3'd0, 4'd4, 32'h4400 + 32'(i), 32'h0);
    do_fatal(3'd4, 4'd12, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 handoff held", 64'(handoff_req), 64'd1);
      check("R7 ready low", 64'(upd_ready), 64'd0);
      check("R7 no restart", 64'(restart_pulse), 64'd0);
    end
    handoff_ack = 1'b1;
    @(negedge clk);
    handoff_ack = 1'b0;
    check("R9 halted", 64'(halted), 64'd1);
    check("R9 handoff drop", 64'(handoff_req), 64'd0);
    upd_valid = 1'b1; upd_err = 3'd0; upd_addr = 4'd1; upd_data = 32'h5A5A_5A5A;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 no commit", 64'(commit_valid), 64'd0);
      check("R9 ready low", 64'(upd_ready), 64'd0);
      check("R9 stays halted", 64'(halted), 64'd1);
    end
    upd_valid = 1'b0;
    read_check("R9 store untouched", 4'd1);
    do_reset();
    check("R9 reset clears halt", 64'(halted), 64'd0);
    check("R9 ready after reset", 64'(upd_ready), 64'd1);
    read_check("R10 cleared", 4'd1);
    check("R5 reset pc", 64'(restart_pc), 64'd0);
  endtask

  initial begin
    seq = 0;
    model_reset();
    do_reset();
    t_reset();
    t_clean();
    t_corr();
    t_fatal();
    t_window();
    t_log();
    t_escalate();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule